// File: doc/BRIEF.md
# Periodic Timer with Output Generator

This block is a free-running up-counter that measures out a programmable interval. Each time the counter arrives at the programmed period it issues a one-cycle interrupt strobe and a matching one-cycle DMA request strobe. It also drives a timer output pin. In pulse style the pin carries a short pulse of selectable width. In toggle style the pin behaves as a divided clock. The pin polarity can be inverted.

Software programs the block through a narrow write port with four word addresses: counter, period, reload value and control. The count source is either an internal clock-enable input or rising edges seen on an asynchronous external pin.

The control word selects one of four run modes:
- off, where the counter holds;
- single-shot, where the block stops after the first match;
- continuous, where the counter wraps;
- continuous with reload, where the period register takes a new value from the reload register on every match.

A self-clearing reset bit in the control word returns the counter and the output to their idle state.

Top module: `tick_timer`

## Requirements
- R1: While the run mode is not off, the counter rises by exactly 1 on each qualified tick and is unchanged on cycles without one; with the source bit at 0 a qualified tick is a cycle with `tickIn` high.
- R2: When a tick moves the counter onto the period value, `irqStrobe` and `dmaStrobe` are both high for the single following cycle, the same cycle in which `countVal` first shows the period value.
- R3: In the continuous modes (run field 2'b10 or 2'b11) the next qualified tick after a match returns the counter to 0.
- R4: With control bit 5 at 0 (pulse style), `statusOut` goes high in the strobe cycle and stays high for w+1 clock cycles, where w is control bits [4:3].
- R5: With control bit 5 at 1 (toggle style), `statusOut` inverts in every strobe cycle.
- R6: `timerOut` equals `statusOut` XOR control bit 6.
- R7: With run field 2'b11, each match copies the reload register into the period register, so `periodVal` shows the reload value in the strobe cycle.
- R8: With run field 2'b01, the first match sets the run field to off, and the counter then holds at the period value with no further strobes.
- R9: With run field 2'b00, the counter holds its value whatever `tickIn` does.
- R10: With control bit 2 at 1, `tickIn` is ignored, and each rising edge on `extIn` advances the counter once. The edge passes through a two-flop synchronizer and an edge detector, so the counter changes on the third rising clock edge after `extIn` rises, and a level held high gives no further ticks.
- R11: A control write with bit 7 set clears the counter to 0 and `statusOut` to 0 at that clock edge. The rest of the written control fields still take effect, and bit 7 is not stored.
- R12: A write with `wrEn` high stores `wrData` into the counter (address 0), period (1), reload (2) or control (3); a counter write has priority over a tick in the same cycle. After reset all registers are 0, the run mode is off and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | Internal count enable |
| extIn | input | 1 | Asynchronous external count pin |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register word address |
| wrData | input | CNT_W | Register write data |
| countVal | output | CNT_W | Current counter value |
| periodVal | output | CNT_W | Current period register value |
| timerOut | output | 1 | Timer output pin, after polarity control |
| statusOut | output | 1 | Generated output state before inversion |
| irqStrobe | output | 1 | One-cycle interrupt on period match |
| dmaStrobe | output | 1 | One-cycle DMA event on period match |

## Verification
The bench builds the block with its default 32-bit counter and two synchronizer stages. It programs periods of only 1 to 5 ticks, so full wrap, reload and toggle sequences complete within a few dozen cycles and can be timed cycle by cycle. With two synchronizer stages the external path has a fixed three-edge latency, which the bench uses to predict the exact cycle each external pulse lands. It also checks that a held level adds nothing. A period of 1000 with a gated `tickIn` exercises the tick qualification without reaching a match.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    EN_OFF    = 2'b00,
    EN_ONCE   = 2'b01,
    EN_CONT   = 2'b10,
    EN_RELOAD = 2'b11
  } enMode_e;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_RELOAD = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;

  localparam int CTL_W           = 8;
  localparam int CTL_SRC_BIT     = 2;
  localparam int CTL_PW_LSB      = 3;
  localparam int PW_W            = 2;
  localparam int CTL_TOGGLE_BIT  = 5;
  localparam int CTL_INV_BIT     = 6;
  localparam int CTL_SWRST_BIT   = 7;

  typedef struct packed {
    enMode_e          mode;
    logic             extSrc;
    logic [PW_W-1:0]  pulseWidth;
    logic             toggleMode;
    logic             invert;
  } timerCfg_t;

  typedef struct packed {
    logic cntInc;
    logic cntLoad;
    logic cntClear;
    logic prdLoad;
    logic relLoad;
    logic reloadArm;
  } dpStrobe_t;

endpackage

// File: rtl/tick_timer_srcsync.sv
module tick_timer_srcsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic syncQ [SYNC_STAGES];
  logic lastQ;

  genvar g;
  for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[LAST];
  end

  assign riseOut = syncQ[LAST] & ~lastQ;
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             extRise,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CTL_W-1:0] ctlData,
  input  logic             hit,
  output timerCfg_t        cfg,
  output dpStrobe_t        strb,
  output logic             swReset,
  output logic             dmaStrobe
);
  logic ctrlWr;
  logic tickQual;
  logic running;

  always_comb begin
    ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
    swReset  = ctrlWr && ctlData[CTL_SWRST_BIT];
    tickQual = cfg.extSrc ? extRise : tickIn;
    running  = (cfg.mode != EN_OFF);

    strb.cntLoad   = wrEn && (wrAddr == ADDR_COUNT);
    strb.cntClear  = swReset;
    strb.cntInc    = running && tickQual && !strb.cntLoad && !swReset;
    strb.prdLoad   = wrEn && (wrAddr == ADDR_PERIOD);
    strb.relLoad   = wrEn && (wrAddr == ADDR_RELOAD);
    strb.reloadArm = (cfg.mode == EN_RELOAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '{mode: EN_OFF, extSrc: 1'b0, pulseWidth: '0, toggleMode: 1'b0, invert: 1'b0};
    end else if (ctrlWr) begin
      cfg.mode       <= enMode_e'(ctlData[1:0]);
      cfg.extSrc     <= ctlData[CTL_SRC_BIT];
      cfg.pulseWidth <= ctlData[CTL_PW_LSB +: PW_W];
      cfg.toggleMode <= ctlData[CTL_TOGGLE_BIT];
      cfg.invert     <= ctlData[CTL_INV_BIT];
    end else if (hit && (cfg.mode == EN_ONCE)) begin
      cfg.mode <= EN_OFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dmaStrobe <= 1'b0;
    else       dmaStrobe <= hit;
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] periodVal,
  output logic             hit,
  output logic             irqStrobe
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] reload;
  logic             wrapPending;
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    nextCount = wrapPending ? '0 : (count + STEP);
    hit       = strb.cntInc && (nextCount == period);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count       <= '0;
      wrapPending <= 1'b0;
    end else if (strb.cntClear) begin
      count       <= '0;
      wrapPending <= 1'b0;
    end else if (strb.cntLoad) begin
      count       <= wrData;
      wrapPending <= 1'b0;
    end else if (strb.cntInc) begin
      count       <= nextCount;
      wrapPending <= hit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         period <= '0;
    else if (strb.prdLoad)             period <= wrData;
    else if (hit && strb.reloadArm)    period <= reload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             reload <= '0;
    else if (strb.relLoad) reload <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqStrobe <= 1'b0;
    else       irqStrobe <= hit;
  end

  assign countVal  = count;
  assign periodVal = period;
endmodule

// File: rtl/tick_timer_outgen.sv
module tick_timer_outgen
  import tick_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  timerCfg_t cfg,
  input  logic      hit,
  input  logic      swReset,
  output logic      genOut,
  output logic      pinOut
);
  logic [PW_W-1:0] widthLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genOut    <= 1'b0;
      widthLeft <= '0;
    end else if (swReset) begin
      genOut    <= 1'b0;
      widthLeft <= '0;
    end else if (hit) begin
      if (cfg.toggleMode) begin
        genOut <= ~genOut;
      end else begin
        genOut    <= 1'b1;
        widthLeft <= cfg.pulseWidth;
      end
    end else if (!cfg.toggleMode && genOut) begin
      if (widthLeft == '0) genOut    <= 1'b0;
      else                 widthLeft <= widthLeft - 1'b1;
    end
  end

  assign pinOut = genOut ^ cfg.invert;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             extIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] periodVal,
  output logic             timerOut,
  output logic             statusOut,
  output logic             irqStrobe,
  output logic             dmaStrobe
);
  timerCfg_t cfg;
  dpStrobe_t strb;
  logic      extRise;
  logic      hit;
  logic      swReset;

  tick_timer_srcsync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .pinIn(extIn), .riseOut(extRise)
  );

  tick_timer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .extRise(extRise),
    .wrEn(wrEn), .wrAddr(wrAddr), .ctlData(wrData[CTL_W-1:0]),
    .hit(hit), .cfg(cfg), .strb(strb), .swReset(swReset), .dmaStrobe(dmaStrobe)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .countVal(countVal), .periodVal(periodVal), .hit(hit), .irqStrobe(irqStrobe)
  );

  tick_timer_outgen outgen_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .hit(hit), .swReset(swReset),
    .genOut(statusOut), .pinOut(timerOut)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CNT_W-1:0] countVal,
  input logic             irqStrobe,
  input logic             dmaStrobe,
  input logic             statusOut,
  input logic             hit,
  input timerCfg_t        cfg,
  input dpStrobe_t        strb
);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntInc && !strb.cntLoad && !strb.cntClear) |=> $stable(countVal));

  // R2
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe == dmaStrobe);

  // R3
  wrap_after_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqStrobe && strb.cntInc) |=> (countVal == '0));

  // R4
  pulse_rise_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.toggleMode && $rose(statusOut)) |-> irqStrobe);

  // R5
  toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqStrobe && cfg.toggleMode && $past(cfg.toggleMode)) |-> (statusOut != $past(statusOut)));

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && (cfg.mode == EN_ONCE) && !wrEn) |=> (cfg.mode == EN_OFF));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .countVal(countVal),
  .irqStrobe(irqStrobe), .dmaStrobe(dmaStrobe), .statusOut(statusOut),
  .hit(hit), .cfg(cfg), .strb(strb)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b1;
  logic        extIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] countVal, periodVal;
  logic        timerOut, statusOut, irqStrobe, dmaStrobe;

  int nChecks = 0;
  int nFail = 0;
  int edgeCnt = 0;
  int expQ[$];
  bit done = 0;

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .extIn(extIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .countVal(countVal), .periodVal(periodVal), .timerOut(timerOut),
    .statusOut(statusOut), .irqStrobe(irqStrobe), .dmaStrobe(dmaStrobe)
  );

  always #10 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edgeCnt);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTo(input int n);
    while (edgeCnt < n) @(negedge clk);
  endtask

  // scoreboard monitor: every match strobe must line up with the next expected edge
  always @(negedge clk) begin
    int e;
    if (rstN && irqStrobe) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected match strobe", edgeCnt, -1);
      end else begin
        e = expQ.pop_front();
        chk(e == edgeCnt, "R2 match strobe timing", edgeCnt, e);
      end
      chk(dmaStrobe == 1'b1, "R2 dma strobe with interrupt", dmaStrobe, 1);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", edgeCnt, 200000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int k, k2, n;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(countVal == 0, "R12 reset counter", countVal, 0);
    chk(periodVal == 0, "R12 reset period", periodVal, 0);
    chk(timerOut == 0 && statusOut == 0, "R12 reset outputs", {timerOut, statusOut}, 0);
    chk(irqStrobe == 0, "R12 reset strobe", irqStrobe, 0);

    // continuous, pulse width 3 cycles, period 3
    wr(2'd1, 32'd3);
    chk(periodVal == 3, "R12 period write", periodVal, 3);
    wr(2'd3, 32'h12);
    k = edgeCnt;
    expQ.push_back(k + 3); expQ.push_back(k + 7); expQ.push_back(k + 11);
    waitTo(k + 1); chk(countVal == 1, "R1 first increment", countVal, 1);
    waitTo(k + 2); chk(countVal == 2, "R1 second increment", countVal, 2);
    waitTo(k + 3); chk(countVal == 3, "R2 counter at period in strobe cycle", countVal, 3);
    chk(statusOut == 1 && timerOut == 1, "R4 pulse starts with strobe", statusOut, 1);
    waitTo(k + 4); chk(countVal == 0, "R3 wrap to zero", countVal, 0);
    waitTo(k + 5); chk(statusOut == 1, "R4 pulse third cycle", statusOut, 1);
    waitTo(k + 6); chk(statusOut == 0, "R4 pulse ended after 3 cycles", statusOut, 0);
    waitTo(k + 11);
    wr(2'd3, 32'd0);
    held = countVal;
    repeat (5) @(negedge clk);
    chk(countVal == held, "R9 off mode holds counter", countVal, held);

    // toggle style with inversion, period 2, then software reset
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd2);
    wr(2'd3, 32'd98);
    k = edgeCnt;
    expQ.push_back(k + 2); expQ.push_back(k + 5); expQ.push_back(k + 8);
    waitTo(k + 1);
    chk(statusOut == 0, "R5 idle before first match", statusOut, 0);
    chk(timerOut == 1, "R6 inverted pin idle high", timerOut, 1);
    waitTo(k + 2);
    chk(statusOut == 1, "R5 toggle at first match", statusOut, 1);
    chk(timerOut == 0, "R6 inverted pin", timerOut, 0);
    waitTo(k + 4); chk(statusOut == 1, "R5 level held between matches", statusOut, 1);
    waitTo(k + 5); chk(statusOut == 0, "R5 toggle at second match", statusOut, 0);
    waitTo(k + 10);
    chk(statusOut == 1 && countVal == 1, "R5 state before reset", statusOut, 1);
    expQ.push_back(k + 13);
    wr(2'd3, 32'd226);
    chk(countVal == 0, "R11 software reset clears counter", countVal, 0);
    chk(statusOut == 0, "R11 software reset clears output", statusOut, 0);
    chk(timerOut == 1, "R11 pin at inactive inverted level", timerOut, 1);
    waitTo(k + 12); chk(countVal == 1, "R11 mode kept after reset", countVal, 1);
    waitTo(k + 13);
    wr(2'd3, 32'd0);

    // reload mode
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'd5);
    wr(2'd3, 32'd3);
    k = edgeCnt;
    expQ.push_back(k + 3); expQ.push_back(k + 9); expQ.push_back(k + 11);
    waitTo(k + 3); chk(periodVal == 5, "R7 period reloaded at match", periodVal, 5);
    waitTo(k + 4); chk(countVal == 0, "R3 wrap in reload mode", countVal, 0);
    waitTo(k + 5);
    wr(2'd2, 32'd1);
    waitTo(k + 9); chk(periodVal == 1, "R7 new reload value taken", periodVal, 1);
    waitTo(k + 11);
    wr(2'd3, 32'd0);

    // single shot
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd4);
    wr(2'd3, 32'd1);
    k = edgeCnt;
    expQ.push_back(k + 4);
    waitTo(k + 4); chk(countVal == 4, "R8 reaches period", countVal, 4);
    waitTo(k + 12); chk(countVal == 4, "R8 holds after single match", countVal, 4);

    // external source, period 2
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd2);
    wr(2'd3, 32'd6);
    repeat (4) @(negedge clk);
    chk(countVal == 0, "R10 tickIn ignored on external source", countVal, 0);
    n = edgeCnt;
    extIn = 1'b1;
    waitTo(n + 2); chk(countVal == 0, "R10 synchronizer latency", countVal, 0);
    waitTo(n + 3); chk(countVal == 1, "R10 one tick per rising edge", countVal, 1);
    extIn = 1'b0;
    waitTo(n + 6); chk(countVal == 1, "R10 held level adds nothing", countVal, 1);
    k2 = edgeCnt;
    expQ.push_back(k2 + 3);
    extIn = 1'b1;
    waitTo(k2 + 3); chk(countVal == 2, "R10 second edge reaches period", countVal, 2);
    extIn = 1'b0;
    waitTo(k2 + 6);
    k2 = edgeCnt;
    extIn = 1'b1;
    waitTo(k2 + 3); chk(countVal == 0, "R3 wrap on external tick", countVal, 0);
    extIn = 1'b0;
    waitTo(k2 + 5);
    wr(2'd3, 32'd0);

    // gated internal ticks
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd1000);
    wr(2'd3, 32'd2);
    for (int i = 0; i < 10; i++) begin
      tickIn = (i % 2 == 0);
      @(negedge clk);
    end
    tickIn = 1'b1;
    chk(countVal == 5, "R1 counts only qualified ticks", countVal, 5);
    wr(2'd3, 32'd0);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2 all expected strobes seen", expQ.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule